// File: doc/BRIEF.md
# Multi-Bank External Interrupt Controller

This block collects 96 external interrupt lines, grouped as three banks of 32, and turns them into 96 per-line interrupt outputs under control of a small word-addressed register bus. Global line `n` belongs to bank `n / 32` and sits at bit `n % 32` of every register of that bank. Each line has a fixed nature set by a per-bank bitmap parameter: a configurable line or a direct line.

A configurable line watches its input for rising and/or falling edges, as enabled per line. It can also be fired by software. When the line is unmasked, such an event latches a pending flag. The pending flag is the line's output, and it stays high until software clears it through a write-one-to-clear register. A direct line has no pending state. Its output follows its input level, gated by its mask bit.

The register window is 0x400 bytes wide. Reads are combinational from the bus address. Writes take effect at the clock edge where `bus_we` is high. Any address outside the five register kinds of each bank reads as zero and ignores writes.

Top module: `xirq_ctrl`

## Requirements
- R1: Line `n` maps to bank `n/32`, bit `n%32`. The word offsets of bank `b` are: rising select at `0x00+0x20*b`, falling select at `0x04+0x20*b`, software trigger at `0x08+0x20*b`, mask at `0x80+0x10*b` and pending at `0x88+0x10*b`.
- R2: The configurable bitmaps are 0x003FFFFF, 0x000A0000 and 0x00740000 for banks 0, 1 and 2, where a 1 marks a configurable line. Reset leaves each mask register at the inverse of its bitmap, and clears the edge selects, the pending bits and every output.
- R3: A rising input edge on an unmasked configurable line whose rising-select bit is 1 sets its pending bit. Its output goes high at the second clock edge after the input changes, and stays high when the input falls again.
- R4: A falling input edge on an unmasked configurable line whose falling-select bit is 1 sets its pending bit and output with the same timing as R3. An edge whose select bit is 0 has no effect.
- R5: An edge on a masked configurable line (mask bit 0) sets neither its pending bit nor its output.
- R6: Writing 1 to a software-trigger bit of an unmasked configurable line sets its pending bit and output at the write's clock edge. Bits for masked lines have no effect, and the software-trigger register always reads 0.
- R7: Writing 1 to a pending bit clears it and drops the line's output at the write's clock edge. Pending bits written with 0 keep their state, and the pending register reads back the current flags.
- R8: When a pending clear and a new trigger on the same line land on the same clock edge, the pending bit and output stay high.
- R9: A direct line's output is its input ANDed with its mask bit, two clock edges after either changes. A direct line never sets a pending bit.
- R10: Addresses other than the R1 registers read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte address in the register window (bits 1:0 ignored) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| line_in | input | 96 | External interrupt inputs |
| line_irq | output | 96 | Per-line interrupt outputs |

## Verification
Each result has a fixed number of clock edges before it is due:
- An input change reaches an output at the second rising edge after it, for both edge-triggered and direct lines.
- A register write takes effect at its own edge. A mask write reaches a direct output one edge later.

The bench drives inputs on falling edges and samples there. It checks that an edge-triggered output is still low after one edge and high after two. It reads registers combinationally right after the write edge. The collision case puts the pending clear exactly on the edge where the input edge is registered.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
    localparam int LINE_W = 32;
    localparam int ADDR_W = 10;
    localparam int WIDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [LINE_W-1:0] rise;
        logic [LINE_W-1:0] fall;
        logic [LINE_W-1:0] mask;
        logic [LINE_W-1:0] pend;
        logic [LINE_W-1:0] dirq;
    } bank_regs_t;

    // word index of each register kind for bank b
    function automatic logic [WIDX_W-1:0] rise_word(int b);
        return WIDX_W'(8 * b);
    endfunction
    function automatic logic [WIDX_W-1:0] fall_word(int b);
        return WIDX_W'(8 * b + 1);
    endfunction
    function automatic logic [WIDX_W-1:0] swt_word(int b);
        return WIDX_W'(8 * b + 2);
    endfunction
    function automatic logic [WIDX_W-1:0] mask_word(int b);
        return WIDX_W'(32 + 4 * b);
    endfunction
    function automatic logic [WIDX_W-1:0] pend_word(int b);
        return WIDX_W'(34 + 4 * b);
    endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int W = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    typedef struct packed {
        logic [W-1:0] cur;
        logic [W-1:0] prv;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.cur = raw;
        smp_d.prv = smp_q.cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign cur = smp_q.cur;
    assign prv = smp_q.prv;
endmodule

// File: rtl/xirq_bank.sv
module xirq_bank
    import xirq_pkg::*;
#(
    parameter logic [LINE_W-1:0] CFG = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_rise,
    input  logic              wr_fall,
    input  logic              wr_swt,
    input  logic              wr_mask,
    input  logic              wr_pend,
    input  logic [LINE_W-1:0] wdata,
    input  logic [LINE_W-1:0] cur,
    input  logic [LINE_W-1:0] prv,
    output logic [LINE_W-1:0] rd_rise,
    output logic [LINE_W-1:0] rd_fall,
    output logic [LINE_W-1:0] rd_mask,
    output logic [LINE_W-1:0] rd_pend,
    output logic [LINE_W-1:0] irq
);
    localparam bank_regs_t RST_VAL = '{rise: '0, fall: '0, mask: ~CFG, pend: '0, dirq: '0};

    bank_regs_t r_d, r_q;
    logic [LINE_W-1:0] edge_hit, swt_hit, set_v, clr_v;

    always_comb begin
        edge_hit = (cur & ~prv & r_q.rise) | (~cur & prv & r_q.fall);
        swt_hit  = wr_swt ? wdata : '0;
        set_v    = (edge_hit | swt_hit) & r_q.mask & CFG;
        clr_v    = wr_pend ? wdata : '0;

        r_d = r_q;
        if (wr_rise) r_d.rise = wdata;
        if (wr_fall) r_d.fall = wdata;
        if (wr_mask) r_d.mask = wdata;
        // a new trigger overrides a clear on the same edge
        r_d.pend = ((r_q.pend & ~clr_v) | set_v) & CFG;
        r_d.dirq = cur & r_q.mask & ~CFG;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign rd_rise = r_q.rise;
    assign rd_fall = r_q.fall;
    assign rd_mask = r_q.mask;
    assign rd_pend = r_q.pend;
    assign irq     = r_q.pend | r_q.dirq;
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int NBANK = 3,
    parameter logic [NBANK*LINE_W-1:0] CFG_MAP = {32'h0074_0000, 32'h000A_0000, 32'h003F_FFFF}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_we,
    input  logic [LINE_W-1:0]       bus_wdata,
    output logic [LINE_W-1:0]       bus_rdata,
    input  logic [NBANK*LINE_W-1:0] line_in,
    output logic [NBANK*LINE_W-1:0] line_irq
);
    localparam int NLINE = NBANK * LINE_W;

    logic [WIDX_W-1:0] widx;
    logic [NLINE-1:0]  s_cur, s_prv;
    logic [LINE_W-1:0] rd_rise [NBANK];
    logic [LINE_W-1:0] rd_fall [NBANK];
    logic [LINE_W-1:0] rd_mask [NBANK];
    logic [LINE_W-1:0] rd_pend [NBANK];

    assign widx = bus_addr[ADDR_W-1:2];

    xirq_sync #(.W(NLINE)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (line_in),
        .cur  (s_cur),
        .prv  (s_prv)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        xirq_bank #(.CFG(CFG_MAP[b*LINE_W +: LINE_W])) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_rise(bus_we && widx == rise_word(b)),
            .wr_fall(bus_we && widx == fall_word(b)),
            .wr_swt (bus_we && widx == swt_word(b)),
            .wr_mask(bus_we && widx == mask_word(b)),
            .wr_pend(bus_we && widx == pend_word(b)),
            .wdata  (bus_wdata),
            .cur    (s_cur[b*LINE_W +: LINE_W]),
            .prv    (s_prv[b*LINE_W +: LINE_W]),
            .rd_rise(rd_rise[b]),
            .rd_fall(rd_fall[b]),
            .rd_mask(rd_mask[b]),
            .rd_pend(rd_pend[b]),
            .irq    (line_irq[b*LINE_W +: LINE_W])
        );
    end

    // software-trigger words and all other addresses fall through to zero
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (widx == rise_word(b)) bus_rdata = rd_rise[b];
            if (widx == fall_word(b)) bus_rdata = rd_fall[b];
            if (widx == mask_word(b)) bus_rdata = rd_mask[b];
            if (widx == pend_word(b)) bus_rdata = rd_pend[b];
        end
    end
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk
    import xirq_pkg::*;
#(
    parameter int NBANK = 3,
    parameter logic [NBANK*LINE_W-1:0] CFG_MAP = '0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic                    bus_we,
    input logic [LINE_W-1:0]       bus_wdata,
    input logic [LINE_W-1:0]       bus_rdata,
    input logic [NBANK*LINE_W-1:0] line_in,
    input logic [NBANK*LINE_W-1:0] line_irq
);
    localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(34 + 4 * (NBANK - 1));

    logic [1:0] since_rst;
    logic       pend_wr;

    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    always_comb begin
        pend_wr = 1'b0;
        for (int b = 0; b < NBANK; b++)
            if (bus_we && bus_addr[ADDR_W-1:2] == pend_word(b)) pend_wr = 1'b1;
    end

    // R7
    cfg_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(line_irq) & ~line_irq & CFG_MAP)) |-> $past(pend_wr));

    // R9
    direct_low_in_low_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3) |-> ((line_irq & ~CFG_MAP & ~$past(line_in, 2)) == '0));

    // R10
    gap_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[ADDR_W-1:2] > LAST_WORD) |-> (bus_rdata == '0));

    for (genvar b = 0; b < NBANK; b++) begin : g_chk
        // R6
        swt_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr[ADDR_W-1:2] == swt_word(b)) |-> (bus_rdata == '0));

        // R7
        pend_read_matches_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr[ADDR_W-1:2] == pend_word(b)) |->
            (bus_rdata == (line_irq[b*LINE_W +: LINE_W] & CFG_MAP[b*LINE_W +: LINE_W])));
    end
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.NBANK(NBANK), .CFG_MAP(CFG_MAP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .line_in  (line_in),
    .line_irq (line_irq)
);

// File: tb/xirq_ctrl_test.sv
module xirq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [95:0] line_in = '0;
    logic [95:0] line_irq;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    xirq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in), .line_irq(line_irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(10'h080, v); chk("R2 mask0 reset", v, 32'hFFC0_0000);
        rd(10'h090, v); chk("R2 mask1 reset", v, 32'hFFF5_FFFF);
        rd(10'h0A0, v); chk("R2 mask2 reset", v, 32'hFF8B_FFFF);
        rd(10'h000, v); chk("R2 rise0 reset", v, 32'h0);
        rd(10'h098, v); chk("R2 pend1 reset", v, 32'h0);
        chk("R2 outputs reset", 32'(|line_irq), 32'h0);
    endtask

    task automatic t_masked_edge();
        logic [31:0] v;
        wr(10'h000, 32'h8);
        line_in[3] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 masked edge irq3", 32'(line_irq[3]), 32'h0);
        rd(10'h088, v); chk("R5 masked edge pend0", v, 32'h0);
        line_in[3] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(10'h080, 32'hFFC0_0008);
        line_in[3] = 1'b1;
        @(negedge clk);
        chk("R3 not yet after one edge", 32'(line_irq[3]), 32'h0);
        @(negedge clk);
        chk("R3 rise sets irq3", 32'(line_irq[3]), 32'h1);
        line_in[3] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 irq3 holds after input low", 32'(line_irq[3]), 32'h1);
        rd(10'h088, v); chk("R3 pend0", v, 32'h8);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(10'h088, 32'h8);
        chk("R7 clear drops irq3", 32'(line_irq[3]), 32'h0);
        rd(10'h088, v); chk("R7 pend0 cleared", v, 32'h0);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        wr(10'h024, 32'h0002_0000);
        wr(10'h090, 32'hFFF7_FFFF);
        line_in[49] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 rise without select ignored", 32'(line_irq[49]), 32'h0);
        line_in[49] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 fall sets irq49", 32'(line_irq[49]), 32'h1);
        rd(10'h098, v); chk("R1 R4 pend1 bit17", v, 32'h0002_0000);
    endtask

    task automatic t_swt();
        logic [31:0] v;
        wr(10'h0A0, 32'hFF9B_FFFF);
        wr(10'h048, 32'h0030_0000);
        chk("R6 sw sets irq84", 32'(line_irq[84]), 32'h1);
        chk("R6 masked sw ignored irq85", 32'(line_irq[85]), 32'h0);
        rd(10'h048, v); chk("R6 swt reads zero", v, 32'h0);
        rd(10'h0A8, v); chk("R6 pend2", v, 32'h0010_0000);
        wr(10'h0A8, 32'h0020_0000);
        chk("R7 zero-write bit keeps irq84", 32'(line_irq[84]), 32'h1);
        rd(10'h098, v); chk("R7 other bank untouched", v, 32'h0002_0000);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(10'h008, 32'h8);
        chk("R6 sw sets irq3", 32'(line_irq[3]), 32'h1);
        line_in[3] = 1'b1;
        @(negedge clk);
        bus_addr = 10'h088; bus_we = 1'b1; bus_wdata = 32'h8;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R8 trigger beats clear irq3", 32'(line_irq[3]), 32'h1);
        rd(10'h088, v); chk("R8 pend0 kept", v, 32'h8);
        line_in[3] = 1'b0;
        repeat (3) @(negedge clk);
        wr(10'h088, 32'h8);
        chk("R7 clear after collide", 32'(line_irq[3]), 32'h0);
    endtask

    task automatic t_direct();
        logic [31:0] v;
        line_in[31] = 1'b1;
        line_in[32] = 1'b1;
        @(negedge clk);
        chk("R9 direct not yet", 32'(line_irq[31]), 32'h0);
        @(negedge clk);
        chk("R9 direct follows input", 32'(line_irq[31]), 32'h1);
        chk("R1 line32 bank1 bit0", 32'(line_irq[32]), 32'h1);
        rd(10'h088, v); chk("R9 no pending for direct", v, 32'h0);
        wr(10'h080, 32'h7FC0_0008);
        @(negedge clk);
        chk("R9 masked direct low", 32'(line_irq[31]), 32'h0);
        line_in[32] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 direct input low", 32'(line_irq[32]), 32'h0);
        line_in[31] = 1'b0;
    endtask

    task automatic t_gap();
        logic [31:0] v;
        wr(10'h084, 32'hFFFF_FFFF);
        rd(10'h084, v); chk("R10 gap 0x84 reads zero", v, 32'h0);
        wr(10'h00C, 32'hFFFF_FFFF);
        rd(10'h000, v); chk("R10 gap write leaves rise0", v, 32'h8);
        rd(10'h080, v); chk("R10 gap write leaves mask0", v, 32'h7FC0_0008);
        rd(10'h3FC, v); chk("R10 top of window zero", v, 32'h0);
    endtask

    initial begin : wd
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked_edge();
        t_rise();
        t_clear();
        t_fall();
        t_swt();
        t_collide();
        t_direct();
        t_gap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule